// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is the master side of a two-wire PHY management bus. It runs clause-22 register read and register write frames. Software, through a host wrapper that sits outside this block, owns two independent command channels. Each channel has a command word that holds a start flag, a direction flag, a PHY address, a register address and 16 data bits. Setting the start flag queues the command. The engine serves one command at a time and clears the flag when the frame has finished. A read places the returned data in the data field of the same word.

The management clock comes from the system clock through a programmable divider. It runs only while the block is enabled. The 32-bit preamble of ones can be switched off for PHYs that accept short frames. The engine keeps a bitmap of the PHYs that answered the last read sent to them. It raises a sticky completion event for each channel and drives an interrupt line through a mask. It also flags a pin fault when the level it reads back from the data line differs from the level it is driving.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Two command words, one per channel, each with this layout: bit 31 start, bit 30 direction (1 = register write), bit 29 acknowledge (read-only), bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. Bits 28:26 read as 0. A host write to an idle channel loads every field except acknowledge, and the word reads back at once. Every readable field is 0 after reset.
- R2: A start flag of 1 queues a frame for that channel. The flag stays 1 until that frame has ended, and then it clears by itself.
- R3: A host write to a channel's command word has no effect while that channel's start flag is 1.
- R4: A write frame carries opcode 01, then turnaround 10 driven, then the 16 data bits driven. A read frame carries opcode 10 and releases the line for both turnaround bits and the 16 data bits. The 16 bits sampled in a read are stored in the data field.
- R5: At the end of a channel's frame, bit c of the raw event vector sets. A clear pulse with 1 in bit c clears that bit; a 0 has no effect. Mask set and mask clear pulses change bit c of the mask, and clear wins when both are 1. The masked vector is raw AND mask, and the interrupt is the OR of the masked bits.
- R6: At the end of a read, the acknowledge bit takes 1 if the PHY drove the second turnaround bit low and 0 otherwise. Bit p of the alive vector, where p is the PHY address, takes the same value. Write frames change neither.
- R7: With the preamble-disable input at 0, each frame starts with 32 ones, for 64 bits in all. With the input at 1, the frame is 32 bits long.
- R8: The fault output sets when the data line, sampled at a rising clock edge while the engine drives it, differs from the driven level. It stays set while the engine is enabled and clears while the enable input is 0.
- R9: The management clock period is (divider + 1) system clock cycles, and a divider of 0 acts as 1. While the enable input is 0 the clock stays low and no frame starts.
- R10: When both start flags are 1, channel 0 is served first. Only one frame runs at a time, and the line is released for at least one clock period between frames.
- R11: Bits are sent MSB first in this order: preamble, start 01, opcode, PHY address, register address, turnaround, data. Driven bits change only on a falling edge of the management clock, and input is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Runs the management clock and allows frames to start |
| clkDiv | input | 8 | Clock divider; the period is clkDiv+1 cycles |
| preambleOff | input | 1 | 1 leaves out the 32-bit preamble |
| cmdWe | input | 2 | Write strobe for each channel's command word |
| cmdWData | input | 32 | Command word to write |
| evtClr | input | 2 | Write-one-to-clear pulse for the raw events |
| maskSet | input | 2 | Pulse that sets interrupt mask bits |
| maskClr | input | 2 | Pulse that clears interrupt mask bits |
| chanCmd0 | output | 32 | Read-back of channel 0's command word |
| chanCmd1 | output | 32 | Read-back of channel 1's command word |
| evtRaw | output | 2 | Sticky completion events |
| evtMasked | output | 2 | Events ANDed with the mask |
| irq | output | 1 | Interrupt request |
| alive | output | 32 | Acknowledge status for each PHY address |
| fault | output | 1 | Pin read-back fault flag |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output level |
| mdoEn | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input |

## Verification
The hardest state to reach is two pending commands that contend for the bus. The starts land on different cycles, so one channel would normally begin before the other's flag is set. The bench therefore drops the enable input, loads channel 1 and then channel 0, and checks that the management clock stays still. After that it raises enable and expects channel 0's frame on the wire first. The pin fault is another case a normal PHY never causes: the bench model inverts the data line it returns during a write frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN  = 32;
  localparam int BODY_LEN = 32;
  localparam int FRAME_W  = PRE_LEN + BODY_LEN;

  typedef struct packed {
    logic               load;       // first bit of a new frame
    logic               advance;    // move to the next bit
    logic               finish;     // frame done, release line
    logic               drive;      // bit being presented is driven
    logic               fallTick;   // mdc falls at this edge
    logic               riseTick;   // mdc rises at this edge
    logic               sampleTa;   // capture acknowledge
    logic               sampleData; // capture a read data bit
    logic [FRAME_W-1:0] frame;      // frame image for load
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PHY_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic                 preambleOff,
  input  logic [1:0]           cmdWe,
  input  logic [31:0]          cmdWData,
  input  logic [1:0]           evtClr,
  input  logic [1:0]           maskSet,
  input  logic [1:0]           maskClr,
  input  logic [15:0]          rxData,
  input  logic                 ackIn,
  output logic [31:0]          chanCmd0,
  output logic [31:0]          chanCmd1,
  output logic [1:0]           evtRaw,
  output logic [1:0]           evtMasked,
  output logic                 irq,
  output logic [(1<<PHY_W)-1:0] alive,
  output logic                 mdc,
  output logic                 busy,
  output mdioStrobe_t          stb
);
  localparam int NUM_CH = 2;
  localparam int IDX_W  = $clog2(FRAME_W) + 1;
  localparam logic [DIV_W-1:0] ONE = 1;
  localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(BODY_LEN - 1);

  // clock divider
  logic [DIV_W-1:0] divCnt, effDiv, hiStart;
  logic [DIV_W:0]   effPlus;
  logic             riseTick, fallTick;

  always_comb begin
    effDiv   = (clkDiv == '0) ? ONE : clkDiv;
    effPlus  = {1'b0, effDiv} + 1'b1;
    hiStart  = effPlus[DIV_W:1];
    riseTick = enable && (divCnt == hiStart - ONE);
    fallTick = enable && (divCnt >= effDiv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (!enable) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else begin
      divCnt <= fallTick ? '0 : divCnt + ONE;
      if (fallTick)      mdc <= 1'b0;
      else if (riseTick) mdc <= 1'b1;
    end
  end

  // channel command words
  logic [NUM_CH-1:0] goQ, wrQ, ackQ;
  logic [4:0]        regQ  [NUM_CH];
  logic [PHY_W-1:0]  phyQ  [NUM_CH];
  logic [15:0]       dataQ [NUM_CH];
  logic [1:0]        maskQ;

  // sequencer state
  logic             running, actCh, curWr, usePre;
  logic [IDX_W-1:0] bitIdx, base;
  logic             selCh, start, finish;
  logic [IDX_W-1:0] nIdx, nBase;
  logic             nWr;
  logic [BODY_LEN-1:0] body;

  always_comb begin
    selCh  = goQ[0] ? 1'b0 : 1'b1;
    base   = usePre ? PRE_I : '0;
    start  = !running && enable && (|goQ) && fallTick;
    finish = running && fallTick && (bitIdx == base + LAST_I);
    nIdx   = start ? '0 : bitIdx + 1'b1;
    nBase  = start ? (preambleOff ? '0 : PRE_I) : base;
    nWr    = start ? wrQ[selCh] : curWr;
    body   = {2'b01, wrQ[selCh] ? 2'b01 : 2'b10, phyQ[selCh], regQ[selCh],
              wrQ[selCh] ? 2'b10 : 2'b11, wrQ[selCh] ? dataQ[selCh] : 16'hFFFF};

    stb            = '0;
    stb.load       = start;
    stb.advance    = running && fallTick && !finish;
    stb.finish     = finish;
    stb.drive      = nWr || (nIdx < nBase + IDX_W'(14));
    stb.fallTick   = fallTick;
    stb.riseTick   = riseTick;
    stb.sampleTa   = running && riseTick && (bitIdx == base + IDX_W'(15));
    stb.sampleData = running && riseTick && (bitIdx >= base + IDX_W'(16));
    stb.frame      = preambleOff ? {body, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, body};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      actCh   <= 1'b0;
      curWr   <= 1'b0;
      usePre  <= 1'b1;
      bitIdx  <= '0;
    end else if (start) begin
      running <= 1'b1;
      actCh   <= selCh;
      curWr   <= wrQ[selCh];
      usePre  <= !preambleOff;
      bitIdx  <= '0;
    end else if (finish) begin
      running <= 1'b0;
    end else if (stb.advance) begin
      bitIdx  <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goQ   <= '0;
      wrQ   <= '0;
      ackQ  <= '0;
      alive <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        regQ[c]  <= '0;
        phyQ[c]  <= '0;
        dataQ[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cmdWe[c] && !goQ[c]) begin
          goQ[c]   <= cmdWData[31];
          wrQ[c]   <= cmdWData[30];
          regQ[c]  <= cmdWData[25:21];
          phyQ[c]  <= cmdWData[16+PHY_W-1:16];
          dataQ[c] <= cmdWData[15:0];
        end
      end
      if (finish) begin
        goQ[actCh] <= 1'b0;
        if (!curWr) begin
          dataQ[actCh]       <= rxData;
          ackQ[actCh]        <= ackIn;
          alive[phyQ[actCh]] <= ackIn;
        end
      end
    end
  end

  // events and mask
  logic [1:0] doneBits;
  always_comb doneBits = finish ? (actCh ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtRaw <= '0;
      maskQ  <= '0;
    end else begin
      evtRaw <= (evtRaw & ~evtClr) | doneBits;
      maskQ  <= (maskQ | maskSet) & ~maskClr;
    end
  end

  always_comb begin
    evtMasked = evtRaw & maskQ;
    irq       = |evtMasked;
    busy      = running;
    chanCmd0  = {goQ[0], wrQ[0], ackQ[0], 3'b000, regQ[0], phyQ[0], dataQ[0]};
    chanCmd1  = {goQ[1], wrQ[1], ackQ[1], 3'b000, regQ[1], phyQ[1], dataQ[1]};
  end

  // assertions
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_go_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(goQ[c]) |-> $past(finish && (actCh == c)));
    p_cmd_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      goQ[c] |=> ($stable(regQ[c]) && $stable(phyQ[c]) && $stable(wrQ[c])));
    p_evt_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evtRaw[c]) |-> $past(finish && (actCh == c)));
  end

  p_idle_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !running) |=> !running);
  p_prio_ch0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && goQ[0]) |=> (actCh == 1'b0));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  mdioStrobe_t stb,
  input  logic        mdiIn,
  output logic        mdo,
  output logic        mdoEn,
  output logic [15:0] rxData,
  output logic        ackOut,
  output logic        fault
);
  logic [FRAME_W-1:0] txShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
      mdo     <= 1'b1;
      mdoEn   <= 1'b0;
    end else if (stb.load) begin
      mdo     <= stb.frame[FRAME_W-1];
      txShift <= {stb.frame[FRAME_W-2:0], 1'b0};
      mdoEn   <= stb.drive;
    end else if (stb.advance) begin
      mdo     <= txShift[FRAME_W-1];
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
      mdoEn   <= stb.drive;
    end else if (stb.finish) begin
      mdo     <= 1'b1;
      mdoEn   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData <= '0;
      ackOut <= 1'b0;
    end else begin
      if (stb.sampleTa)   ackOut <= !mdiIn;
      if (stb.sampleData) rxData <= {rxData[14:0], mdiIn};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          fault <= 1'b0;
    else if (!enable)                                    fault <= 1'b0;
    else if (stb.riseTick && mdoEn && (mdiIn != mdo))    fault <= 1'b1;
  end

  p_mdo_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdo != $past(mdo)) |-> $past(stb.fallTick));
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fault) |=> fault);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PHY_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [DIV_W-1:0]      clkDiv,
  input  logic                  preambleOff,
  input  logic [1:0]            cmdWe,
  input  logic [31:0]           cmdWData,
  input  logic [1:0]            evtClr,
  input  logic [1:0]            maskSet,
  input  logic [1:0]            maskClr,
  output logic [31:0]           chanCmd0,
  output logic [31:0]           chanCmd1,
  output logic [1:0]            evtRaw,
  output logic [1:0]            evtMasked,
  output logic                  irq,
  output logic [(1<<PHY_W)-1:0] alive,
  output logic                  fault,
  output logic                  mdc,
  output logic                  mdo,
  output logic                  mdoEn,
  input  logic                  mdi
);
  mdioStrobe_t stb;
  logic [15:0] rxData;
  logic        ackBit, busy;

  mdio_ctrl #(.DIV_W(DIV_W), .PHY_W(PHY_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clkDiv(clkDiv),
    .preambleOff(preambleOff), .cmdWe(cmdWe), .cmdWData(cmdWData),
    .evtClr(evtClr), .maskSet(maskSet), .maskClr(maskClr),
    .rxData(rxData), .ackIn(ackBit), .chanCmd0(chanCmd0), .chanCmd1(chanCmd1),
    .evtRaw(evtRaw), .evtMasked(evtMasked), .irq(irq), .alive(alive),
    .mdc(mdc), .busy(busy), .stb(stb)
  );

  mdio_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stb(stb), .mdiIn(mdi),
    .mdo(mdo), .mdoEn(mdoEn), .rxData(rxData), .ackOut(ackBit), .fault(fault)
  );

  p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdoEn);
endmodule

// File: tb/test_mdio_cmd_engine.sv
`timescale 1ns/1ps
module test_mdio_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  clkDiv = 8'd3;
  logic        preambleOff = 1'b0;
  logic [1:0]  cmdWe = '0;
  logic [31:0] cmdWData = '0;
  logic [1:0]  evtClr = '0, maskSet = '0, maskClr = '0;
  logic [31:0] chanCmd0, chanCmd1, alive;
  logic [1:0]  evtRaw, evtMasked;
  logic        irq, fault, mdc, mdo, mdoEn;
  logic        phyDrv = 1'b1;
  logic        flip = 1'b0;
  wire         lineW = mdoEn ? mdo : phyDrv;
  wire         mdiW  = lineW ^ flip;

  always #2.5 clk = ~clk;

  mdio_cmd_engine i_mdio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clkDiv(clkDiv),
    .preambleOff(preambleOff), .cmdWe(cmdWe), .cmdWData(cmdWData),
    .evtClr(evtClr), .maskSet(maskSet), .maskClr(maskClr),
    .chanCmd0(chanCmd0), .chanCmd1(chanCmd1), .evtRaw(evtRaw),
    .evtMasked(evtMasked), .irq(irq), .alive(alive), .fault(fault),
    .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn), .mdi(mdiW)
  );

  typedef struct {
    int          len;
    logic [63:0] bits;
    logic        isRead;
    logic        ack;
    logic [15:0] resp;
    int          ch;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0, errors = 0, mdcEdges = 0;
  bit  benchPreOff = 1'b0, finished = 1'b0;
  bit  phyPresent [32];

  always @(posedge mdc) mdcEdges++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic phyBit(input expItem_t it, input int bb);
    if (!it.isRead || !it.ack) return 1'b1;
    if (bb == 15) return 1'b0;
    if (bb >= 16) return it.resp[31-bb];
    return 1'b1;
  endfunction

  // driver: push expected frame, then write the command word
  task automatic pushCmd(input int ch, input bit wr, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] data,
                         input logic [15:0] resp);
    expItem_t it;
    logic [31:0] bdy;
    it.isRead = !wr;
    it.ack    = wr ? 1'b0 : phyPresent[phy];
    it.resp   = resp;
    it.ch     = ch;
    it.len    = benchPreOff ? 32 : 64;
    bdy = {2'b01, wr ? 2'b01 : 2'b10, phy, rg,
           wr ? 2'b10 : {1'b1, !it.ack},
           wr ? data : (it.ack ? resp : 16'hFFFF)};
    it.bits = benchPreOff ? {32'h0, bdy} : {32'hFFFF_FFFF, bdy};
    expQ.push_back(it);
  endtask

  task automatic hostWrite(input int ch, input logic [31:0] w);
    @(negedge clk);
    cmdWData = w;
    cmdWe[ch] = 1'b1;
    @(negedge clk);
    cmdWe = '0;
  endtask

  function automatic logic [31:0] mkWord(input bit go, input bit wr, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] data);
    return {go, wr, 1'b0, 3'b000, rg, phy, data};
  endfunction

  task automatic runCmd(input int ch, input bit wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] data, input logic [15:0] resp);
    pushCmd(ch, wr, phy, rg, data, resp);
    hostWrite(ch, mkWord(1'b1, wr, phy, rg, data));
  endtask

  task automatic waitIdle(input int ch);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((ch == 0) ? chanCmd0[31] : chanCmd1[31]) && n < 3000);
    chk("R2 start flag self-clears", (ch == 0) ? chanCmd0[31] : chanCmd1[31], 0);
  endtask

  task automatic pulse(input int which, input logic [1:0] v);
    @(negedge clk);
    if (which == 0) evtClr = v; else if (which == 1) maskSet = v; else maskClr = v;
    @(negedge clk);
    evtClr = '0; maskSet = '0; maskClr = '0;
  endtask

  // monitor: PHY model and frame scoreboard
  initial begin
    forever begin
      @(posedge mdc);
      if (mdoEn === 1'b1) begin
        if (expQ.size() == 0) begin
          chk("R10 unexpected frame", 1, 0);
        end else begin
          expItem_t it;
          logic [63:0] got;
          int pre;
          it  = expQ.pop_front();
          pre = it.len - 32;
          got = {63'h0, lineW};
          for (int b = 1; b < it.len; b++) begin
            @(negedge mdc);
            phyDrv = phyBit(it, b - pre);
            @(posedge mdc);
            got = {got[62:0], lineW};
          end
          @(negedge mdc);
          phyDrv = 1'b1;
          chk($sformatf("R4 R7 R11 frame bits ch%0d", it.ch), got, it.bits);
          @(posedge mdc);
          chk("R10 line released between frames", mdoEn, 0);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    realtime t0, t1;
    logic [31:0] w;
    foreach (phyPresent[i]) phyPresent[i] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset ch0", chanCmd0, 0);
    chk("R1 reset ch1", chanCmd1, 0);
    chk("R5 reset irq", irq, 0);
    chk("R6 reset alive", alive, 0);
    chk("R8 reset fault", fault, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: load idle channel, no start
    w = mkWord(1'b0, 1'b1, 5'h11, 5'h0A, 16'hBEEF);
    hostWrite(1, w);
    chk("R1 idle load readback", chanCmd1, w);

    // R9: clock period
    enable = 1'b1;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R9 period div3", int'((t1 - t0) / 5.0), 4);
    clkDiv = 8'd4;
    @(posedge mdc); @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R9 period div4", int'((t1 - t0) / 5.0), 5);
    clkDiv = 8'd0;
    @(posedge mdc); @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R9 period div0 acts as 1", int'((t1 - t0) / 5.0), 2);
    clkDiv = 8'd3;
    repeat (10) @(negedge clk);

    // write frame with preamble, and R3 blocking
    w = mkWord(1'b1, 1'b1, 5'd3, 5'd4, 16'hA5C3);
    runCmd(0, 1'b1, 5'd3, 5'd4, 16'hA5C3, 16'h0);
    repeat (10) @(negedge clk);
    hostWrite(0, 32'h0000_1234);
    chk("R3 write ignored while busy", chanCmd0, w);
    waitIdle(0);
    chk("R3 fields kept after write frame", chanCmd0, {1'b0, w[30:0]});
    chk("R5 raw event ch0", evtRaw, 2'b01);
    chk("R5 irq masked off", irq, 0);
    chk("R8 no fault on clean write", fault, 0);

    // R5 mask and clear
    pulse(1, 2'b01);
    chk("R5 masked after set", evtMasked, 2'b01);
    chk("R5 irq after mask set", irq, 1);
    pulse(0, 2'b10);
    chk("R5 zero bit has no effect", evtRaw, 2'b01);
    pulse(0, 2'b01);
    chk("R5 write-one clears", evtRaw, 2'b00);
    chk("R5 irq drops", irq, 0);

    // R6 acknowledged read on ch1
    phyPresent[3] = 1'b1;
    runCmd(1, 1'b0, 5'd3, 5'd2, 16'hBEEF, 16'h1234);
    waitIdle(1);
    chk("R4 read data stored", chanCmd1[15:0], 16'h1234);
    chk("R6 ack bit set", chanCmd1[29], 1);
    chk("R6 alive set", alive[3], 1);
    chk("R5 raw event ch1", evtRaw, 2'b10);

    // R6 alive set then cleared
    phyPresent[7] = 1'b1;
    runCmd(0, 1'b0, 5'd7, 5'd9, 16'h0, 16'h0F0F);
    waitIdle(0);
    chk("R6 alive phy7 set", alive[7], 1);
    chk("R4 read data phy7", chanCmd0[15:0], 16'h0F0F);
    phyPresent[7] = 1'b0;
    runCmd(0, 1'b0, 5'd7, 5'd9, 16'h0, 16'h0F0F);
    waitIdle(0);
    chk("R6 alive phy7 cleared", alive[7], 0);
    chk("R6 ack bit clear", chanCmd0[29], 0);
    chk("R4 released data reads ones", chanCmd0[15:0], 16'hFFFF);

    // R7 no preamble
    preambleOff = 1'b1;
    benchPreOff = 1'b1;
    runCmd(1, 1'b1, 5'd1, 5'h1F, 16'h8001, 16'h0);
    waitIdle(1);
    runCmd(0, 1'b0, 5'd3, 5'd1, 16'h0, 16'hC0DE);
    waitIdle(0);
    chk("R7 short read data", chanCmd0[15:0], 16'hC0DE);
    preambleOff = 1'b0;
    benchPreOff = 1'b0;

    // R9 disabled and R10 priority
    @(negedge clk);
    enable = 1'b0;
    pulse(0, 2'b11);
    begin
      int edges0;
      edges0 = mdcEdges;
      pushCmd(0, 1'b0, 5'd3, 5'd6, 16'h0, 16'h6666);
      pushCmd(1, 1'b1, 5'd2, 5'd5, 16'h5555, 16'h0);
      hostWrite(1, mkWord(1'b1, 1'b1, 5'd2, 5'd5, 16'h5555));
      hostWrite(0, mkWord(1'b1, 1'b0, 5'd3, 5'd6, 16'h0));
      repeat (100) @(negedge clk);
      chk("R9 no clock while disabled", mdcEdges, edges0);
      chk("R9 commands stay pending", {chanCmd0[31], chanCmd1[31]}, 2'b11);
      chk("R9 line released while disabled", mdoEn, 0);
    end
    enable = 1'b1;
    waitIdle(0);
    chk("R10 ch1 still pending after ch0", chanCmd1[31], 1);
    waitIdle(1);
    chk("R10 both events", evtRaw, 2'b11);
    chk("R10 ch0 read result", chanCmd0[15:0], 16'h6666);

    // R8 fault
    flip = 1'b1;
    runCmd(0, 1'b1, 5'd4, 5'd3, 16'h0F0F, 16'h0);
    waitIdle(0);
    flip = 1'b0;
    chk("R8 fault set on mismatch", fault, 1);
    runCmd(1, 1'b1, 5'd4, 5'd3, 16'h1111, 16'h0);
    waitIdle(1);
    chk("R8 fault sticky", fault, 1);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 fault cleared when disabled", fault, 0);
    enable = 1'b1;

    repeat (200) @(negedge clk);
    chk("R10 all frames seen", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule